// File: doc/BRIEF.md
# Scanned Multi-Channel Event Counter

This block serves a bank of external event inputs with one shared scanner instead of a private edge detector per input. Each input is brought into the clock domain by a two-flop synchroniser. A round-robin scanner then spends a fixed number of clock cycles on each channel. At the end of that visit it hands the channel's synchronised level to the channel's own small state machine, which decides whether a rising edge occurred and what to do with it.

Each channel is set up through a configuration write port and runs in one of four modes. Up counting either wraps or saturates. Down counting stops at zero and raises a zero flag. Frequency measurement counts edges over a programmed number of visits and then latches the total. Period measurement counts visits between successive rising edges. A read port returns any channel's result, its result-valid flag and its zero flag. Reading a channel clears its valid flag.

A channel is visited once every `N_CH × VISIT_CYC` cycles. An input must therefore stay high and low for at least that long to be counted reliably, so the highest input frequency is 1/(2 × N_CH × VISIT_CYC × Tclk).

Top module: `evc_bank`

## Requirements
- R1: After a synchronous active-low reset, every channel reads result 0, valid 0 and zero 0, and sits disabled in up mode.
- R2: Each input passes through two flip-flops. The scanner visits channels in ascending order and wraps to 0 after the last one. Each visit lasts `VISIT_CYC` cycles and acts on its final cycle. A rising edge is counted when the level sampled at this visit is 1 and the level sampled at the previous visit of that channel was 0.
- R3: In up mode (code 0), each edge increments the result. At all-ones the result goes to 0 when the channel's wrap bit is 1 and stays at all-ones when it is 0.
- R4: In down mode (code 1), each edge decrements a non-zero result. Reaching 0 sets the zero flag. At 0, further edges change nothing. Loading 0 in down mode sets the zero flag at once.
- R5: In frequency mode (code 2), each visit adds the edge, if any, to a saturating accumulator. The visit that completes `gate` visits latches the sum into the result and clears the accumulator. A gate value of 0 behaves as 1.
- R6: In period mode (code 3), a saturating reference count grows by one each visit. On an edge, the incremented count is latched as the result and the reference restarts from 0.
- R7: The valid flag is set whenever a result is written by R3–R6. A read cycle (`rd_en` with `rd_ch`) clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: A configuration write for a channel loads mode, enable, wrap and gate. It loads `cfg_load` into the result, clears the accumulator, the gate count and the valid flag, and replaces any update the visit of that same cycle would have made.
- R9: A disabled channel leaves its result unchanged and never sets valid, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_in | input | N_CH | Asynchronous event inputs, one per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_mode | input | 2 | Mode: 0 up, 1 down, 2 frequency, 3 period |
| cfg_en | input | 1 | Channel enable |
| cfg_wrap | input | 1 | Up mode: 1 wrap, 0 saturate |
| cfg_gate | input | GATE_W | Frequency gate length in visits |
| cfg_load | input | CNT_W | Initial result value |
| rd_en | input | 1 | Read strobe; clears the valid flag of `rd_ch` |
| rd_ch | input | CH_W | Channel selected for readback |
| rd_data | output | CNT_W | Result of `rd_ch` |
| rd_valid | output | 1 | Result-valid flag of `rd_ch` |
| rd_zero | output | 1 | Zero flag of `rd_ch` |

## Verification
Two collisions can land in one clock edge: a read that clears a channel's valid flag against a latch that sets it, and a configuration write against that channel's own visit. The bench pulses reads on every third cycle while stepping `rd_ch`, and it reconfigures channels at times that drift relative to the scan. Both collisions therefore happen many times over the run. Each is judged by a behavioural model, updated every clock, that gives the set priority over the clear and gives the write priority over the visit. The model's result, valid and zero for the selected channel are compared with the ports on every cycle.

// File: rtl/evc_pkg.sv
// Shared types for the scanned event counter.
package evc_pkg;
    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_FREQ   = 2'd2,
        MODE_PERIOD = 2'd3
    } evc_mode_e;
endpackage

// File: rtl/evc_sync.sv
// Two-flop synchroniser for every event input.
// Assumes: inputs are asynchronous levels; the reset value of each stage is 0.
module evc_sync #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] async_in,
    output logic [N_CH-1:0] sync_out
);
    for (genvar g = 0; g < N_CH; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        // Move the input through two stages before anything uses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end
        assign sync_out[g] = stab_q;
    end
endmodule

// File: rtl/evc_scanner.sv
// Round-robin scanner. It stays on each channel for VISIT_CYC cycles and
// raises visit on the last cycle of the stay.
// Assumes: VISIT_CYC >= 2 and N_CH >= 2.
module evc_scanner #(
    parameter int N_CH      = 4,
    parameter int VISIT_CYC = 14,
    parameter int CH_W      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [CH_W-1:0] scan_ch,
    output logic            visit
);
    localparam int PH_W = $clog2(VISIT_CYC);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(VISIT_CYC - 1);
    localparam logic [CH_W-1:0] CH_LAST = CH_W'(N_CH - 1);

    logic [PH_W-1:0] phase_q;
    logic [CH_W-1:0] ch_q;

    assign visit   = (phase_q == PH_LAST);
    assign scan_ch = ch_q;

    // Step the phase inside a visit and move to the next channel at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            ch_q    <= '0;
        end else if (visit) begin
            phase_q <= '0;
            ch_q    <= (ch_q == CH_LAST) ? '0 : ch_q + 1'b1;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    p_ch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && scan_ch != CH_LAST) |=> scan_ch == $past(scan_ch) + 1'b1);
    p_ch_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && scan_ch == CH_LAST) |=> scan_ch == '0);
    p_ch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !visit |=> $stable(scan_ch));
endmodule

// File: rtl/evc_channel.sv
// State of one channel: the previous sampled level, mode settings, result,
// accumulator/reference count, gate count, valid and zero flags.
// It acts only on the cycle its visit ends, a configuration write or a read.
// Assumes: sample is already synchronised; a configuration write wins over all else.
module evc_channel
    import evc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              visit_hit,
    input  logic              sample,
    input  logic              cfg_hit,
    input  evc_mode_e         cfg_mode,
    input  logic              cfg_en,
    input  logic              cfg_wrap,
    input  logic [GATE_W-1:0] cfg_gate,
    input  logic [CNT_W-1:0]  cfg_load,
    input  logic              rd_hit,
    output logic [CNT_W-1:0]  result,
    output logic              valid,
    output logic              zero
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    evc_mode_e         mode_q;
    logic              en_q;
    logic              wrap_q;
    logic [GATE_W-1:0] gate_q;
    logic              prev_q;
    logic [CNT_W-1:0]  res_q;
    logic [CNT_W-1:0]  work_q;
    logic [GATE_W-1:0] gc_q;
    logic              valid_q;
    logic              zero_q;

    logic              act;
    logic              edge_seen;
    logic              upd;
    logic [CNT_W-1:0]  nres;
    logic [CNT_W-1:0]  nwork;
    logic [CNT_W-1:0]  work_inc;
    logic [GATE_W-1:0] ngc;
    logic              nzero;

    assign act       = visit_hit && en_q;
    assign edge_seen = act && sample && !prev_q;

    // Work out the channel's next state for its mode from this visit.
    always_comb begin
        upd   = 1'b0;
        nres  = res_q;
        nwork = work_q;
        ngc   = gc_q;
        nzero = zero_q;
        work_inc = work_q;
        unique case (mode_q)
            MODE_UP: begin
                if (edge_seen) begin
                    if (res_q != MAXV) begin
                        nres = res_q + 1'b1;
                        upd  = 1'b1;
                    end else if (wrap_q) begin
                        nres = '0;
                        upd  = 1'b1;
                    end
                end
            end
            MODE_DOWN: begin
                if (edge_seen && res_q != '0) begin
                    nres = res_q - 1'b1;
                    upd  = 1'b1;
                    if (res_q == CNT_W'(1)) nzero = 1'b1;
                end
            end
            MODE_FREQ: begin
                work_inc = (work_q == MAXV) ? work_q : work_q + CNT_W'(edge_seen);
                if (act) begin
                    if (({1'b0, gc_q} + 1'b1) >= {1'b0, gate_q}) begin
                        nres  = work_inc;
                        nwork = '0;
                        ngc   = '0;
                        upd   = 1'b1;
                    end else begin
                        nwork = work_inc;
                        ngc   = gc_q + 1'b1;
                    end
                end
            end
            MODE_PERIOD: begin
                work_inc = (work_q == MAXV) ? work_q : work_q + 1'b1;
                if (act) begin
                    if (edge_seen) begin
                        nres  = work_inc;
                        nwork = '0;
                        upd   = 1'b1;
                    end else begin
                        nwork = work_inc;
                    end
                end
            end
            default: ;
        endcase
    end

    // Commit a configuration write, otherwise the visit result and read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_UP;
            en_q    <= 1'b0;
            wrap_q  <= 1'b0;
            gate_q  <= '0;
            prev_q  <= 1'b0;
            res_q   <= '0;
            work_q  <= '0;
            gc_q    <= '0;
            valid_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            if (visit_hit) prev_q <= sample;
            if (cfg_hit) begin
                mode_q  <= cfg_mode;
                en_q    <= cfg_en;
                wrap_q  <= cfg_wrap;
                gate_q  <= cfg_gate;
                res_q   <= cfg_load;
                work_q  <= '0;
                gc_q    <= '0;
                valid_q <= 1'b0;
                zero_q  <= (cfg_mode == MODE_DOWN) && (cfg_load == '0);
            end else begin
                res_q  <= nres;
                work_q <= nwork;
                gc_q   <= ngc;
                zero_q <= nzero;
                if (upd)         valid_q <= 1'b1;
                else if (rd_hit) valid_q <= 1'b0;
            end
        end
    end

    assign result = res_q;
    assign valid  = valid_q;
    assign zero   = zero_q;

    p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> (result == $past(cfg_load)) && !valid);
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_hit && mode_q == MODE_UP && !wrap_q && result == MAXV) |=> result == MAXV);
    p_zero_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_hit && mode_q == MODE_DOWN && zero) |=> (result == '0) && zero);
    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !cfg_hit && !upd) |=> !valid);
    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_hit && !en_q) |=> $stable(result));
endmodule

// File: rtl/evc_bank.sv
// Top of the scanned event counter: synchronisers, one scanner, a generated
// bank of channel state machines and the readback mux.
// Assumes: rd_ch and cfg_ch address channels below N_CH.
module evc_bank
    import evc_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int CNT_W     = 16,
    parameter int GATE_W    = 8,
    parameter int VISIT_CYC = 14,
    parameter int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   ev_in,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_en,
    input  logic              cfg_wrap,
    input  logic [GATE_W-1:0] cfg_gate,
    input  logic [CNT_W-1:0]  cfg_load,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CNT_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              rd_zero
);
    logic [N_CH-1:0]  sync_lvl;
    logic [CH_W-1:0]  scan_ch;
    logic             visit;
    logic             scan_sample;
    logic [CNT_W-1:0] res_arr [N_CH];
    logic [N_CH-1:0]  valid_vec;
    logic [N_CH-1:0]  zero_vec;

    evc_sync #(.N_CH(N_CH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ev_in),
        .sync_out (sync_lvl)
    );

    evc_scanner #(.N_CH(N_CH), .VISIT_CYC(VISIT_CYC), .CH_W(CH_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_ch (scan_ch),
        .visit   (visit)
    );

    assign scan_sample = sync_lvl[scan_ch];

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        evc_channel #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .visit_hit (visit && (scan_ch == CH_W'(g))),
            .sample    (scan_sample),
            .cfg_hit   (cfg_we && (cfg_ch == CH_W'(g))),
            .cfg_mode  (evc_mode_e'(cfg_mode)),
            .cfg_en    (cfg_en),
            .cfg_wrap  (cfg_wrap),
            .cfg_gate  (cfg_gate),
            .cfg_load  (cfg_load),
            .rd_hit    (rd_en && (rd_ch == CH_W'(g))),
            .result    (res_arr[g]),
            .valid     (valid_vec[g]),
            .zero      (zero_vec[g])
        );
    end

    // Select the addressed channel for readback.
    always_comb begin
        rd_data  = res_arr[rd_ch];
        rd_valid = valid_vec[rd_ch];
        rd_zero  = zero_vec[rd_ch];
    end
endmodule

// File: tb/evc_bank_tb.sv
// Bench: a behavioural model of every channel, stepped on each rising edge
// and compared with the read port on every falling edge.
module evc_bank_tb;
    localparam int  N    = 4;
    localparam int  CW   = 16;
    localparam int  GW   = 8;
    localparam int  VC   = 14;
    localparam time TCLK = 10;
    localparam int  MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ev_in = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_ch = '0;
    logic [1:0]    cfg_mode = '0;
    logic          cfg_en = 1'b0;
    logic          cfg_wrap = 1'b0;
    logic [GW-1:0] cfg_gate = '0;
    logic [CW-1:0] cfg_load = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_ch = '0;
    logic [CW-1:0] rd_data;
    logic          rd_valid;
    logic          rd_zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string phase_tag = "R1";
    int half [N];

    // model state
    int m_res [N], m_work [N], m_gc [N], m_mode [N], m_gate [N];
    bit m_prev [N], m_valid [N], m_zero [N], m_en [N], m_wrap [N];
    bit m_s1 [N], m_s2 [N];
    int m_phase, m_ch;

    evc_bank u_dut (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_mode(cfg_mode), .cfg_en(cfg_en), .cfg_wrap(cfg_wrap), .cfg_gate(cfg_gate),
        .cfg_load(cfg_load), .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_zero(rd_zero)
    );

    always #(TCLK/2) clk = ~clk;

    // Behavioural reference, one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_res[i] = 0; m_work[i] = 0; m_gc[i] = 0; m_mode[i] = 0; m_gate[i] = 0;
                m_prev[i] = 0; m_valid[i] = 0; m_zero[i] = 0; m_en[i] = 0; m_wrap[i] = 0;
                m_s1[i] = 0; m_s2[i] = 0;
            end
            m_phase = 0; m_ch = 0;
        end else begin
            bit visit;
            visit = (m_phase == VC - 1);
            for (int i = 0; i < N; i++) begin
                bit hit, edg, set;
                int inc;
                hit = visit && (m_ch == i);
                edg = hit && m_en[i] && m_s2[i] && !m_prev[i];
                if (hit) m_prev[i] = m_s2[i];
                set = 0;
                if (cfg_we && cfg_ch == i) begin
                    m_mode[i] = cfg_mode; m_en[i] = cfg_en; m_wrap[i] = cfg_wrap;
                    m_gate[i] = cfg_gate; m_res[i] = cfg_load; m_work[i] = 0; m_gc[i] = 0;
                    m_valid[i] = 0; m_zero[i] = (cfg_mode == 1) && (cfg_load == 0);
                end else begin
                    case (m_mode[i])
                        0: if (edg) begin
                            if (m_res[i] != MAXV) begin m_res[i]++; set = 1; end
                            else if (m_wrap[i]) begin m_res[i] = 0; set = 1; end
                        end
                        1: if (edg && m_res[i] != 0) begin
                            m_res[i]--; set = 1;
                            if (m_res[i] == 0) m_zero[i] = 1;
                        end
                        2: if (hit && m_en[i]) begin
                            inc = (m_work[i] == MAXV) ? MAXV : m_work[i] + int'(edg);
                            if (m_gc[i] + 1 >= m_gate[i]) begin
                                m_res[i] = inc; m_work[i] = 0; m_gc[i] = 0; set = 1;
                            end else begin
                                m_work[i] = inc; m_gc[i]++;
                            end
                        end
                        default: if (hit && m_en[i]) begin
                            inc = (m_work[i] == MAXV) ? MAXV : m_work[i] + 1;
                            if (edg) begin m_res[i] = inc; m_work[i] = 0; set = 1; end
                            else m_work[i] = inc;
                        end
                    endcase
                    if (set) m_valid[i] = 1;
                    else if (rd_en && rd_ch == i) m_valid[i] = 0;
                end
            end
            for (int i = 0; i < N; i++) begin
                m_s2[i] = m_s1[i];
                m_s1[i] = ev_in[i];
            end
            if (visit) begin
                m_phase = 0;
                m_ch = (m_ch + 1) % N;
            end else begin
                m_phase++;
            end
        end
    end

    function automatic string mode_tag(int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Compare the selected channel with the model.
    task automatic compare();
        int c;
        c = rd_ch;
        checks++;
        if (rd_data !== CW'(m_res[c])) begin
            fails++;
            $display("FAIL %s/%s ch%0d result actual=%0d expected=%0d", mode_tag(m_mode[c]),
                     phase_tag, c, rd_data, m_res[c]);
        end
        checks++;
        if (rd_valid !== m_valid[c]) begin
            fails++;
            $display("FAIL R7/%s ch%0d valid actual=%0b expected=%0b", phase_tag, c,
                     rd_valid, m_valid[c]);
        end
        checks++;
        if (rd_zero !== m_zero[c]) begin
            fails++;
            $display("FAIL R4/%s ch%0d zero actual=%0b expected=%0b", phase_tag, c,
                     rd_zero, m_zero[c]);
        end
    endtask

    // Falling-edge loop: check, then drive inputs and the read port.
    initial begin
        int tcnt [N];
        int cyc;
        cyc = 0;
        for (int i = 0; i < N; i++) begin tcnt[i] = 0; half[i] = 0; end
        forever begin
            @(negedge clk);
            if (done) break;
            if (rst_n) compare();
            for (int i = 0; i < N; i++) begin
                if (half[i] > 0) begin
                    tcnt[i]++;
                    if (tcnt[i] >= half[i]) begin
                        tcnt[i] = 0;
                        ev_in[i] = ~ev_in[i];
                    end
                end
            end
            cyc++;
            rd_en = (cyc % 3 == 0);
            if (cyc % 7 == 0) rd_ch = rd_ch + 1'b1;
        end
    end

    task automatic cfg(int ch, int mode, bit en, bit wrap, int gate, int load);
        @(negedge clk);
        cfg_ch = 2'(ch); cfg_mode = 2'(mode); cfg_en = en; cfg_wrap = wrap;
        cfg_gate = GW'(gate); cfg_load = CW'(load); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=finished");
        done = 1;
        report();
        $finish;
    end

    // Directed sequence.
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        phase_tag = "R1";                       // reset state is read back first
        half[0] = 70; half[1] = 130; half[2] = 90; half[3] = 200;
        repeat (60) @(negedge clk);
        phase_tag = "R2";                       // scan-based edge detection, all modes
        cfg(0, 0, 1, 0, 0, MAXV - 3);           // up, saturating near the top (R3)
        cfg(1, 1, 1, 0, 0, 5);                  // down from 5 to the zero floor (R4)
        cfg(2, 2, 1, 0, 3, 0);                  // frequency, gate of 3 visits (R5)
        cfg(3, 3, 1, 0, 0, 0);                  // period measurement (R6)
        repeat (8000) @(negedge clk);
        phase_tag = "R8";                       // rewrite channels while they run
        cfg(0, 0, 1, 1, 0, MAXV - 1);           // up with wrap (R3)
        cfg(2, 2, 1, 0, 0, 7);                  // gate 0 acts as 1 (R5)
        cfg(1, 1, 1, 0, 0, 0);                  // load 0 in down mode (R4)
        repeat (3000) @(negedge clk);
        phase_tag = "R9";                       // disabled channels must not move
        cfg(1, 0, 0, 0, 0, 42);
        cfg(3, 3, 0, 0, 0, 9);
        half[1] = 20; half[3] = 25;
        repeat (3000) @(negedge clk);
        phase_tag = "R2";                       // inputs faster than the scan
        cfg(3, 0, 1, 1, 0, 0);
        cfg(2, 2, 1, 0, 200, 0);
        half[3] = 30; half[2] = 17;
        for (int k = 0; k < 40; k++) begin
            cfg(k % N, k % 4, 1, k[0], k % 5, k * 3);
            repeat (37 + k) @(negedge clk);
        end
        repeat (2000) @(negedge clk);
        done = 1;
        @(negedge clk);
        report();
        $finish;
    end
endmodule